// File: doc/BRIEF.md
# Load Value Replication Queue

Two redundant copies of a thread run the same program a few cycles apart. Only the leading copy reads the data cache. Each value it loads is written into this queue together with the load address, in program order. The trailing copy never reads the cache. Its loads are served from the head of the queue instead, so both copies consume the same input. This holds even if another agent or an I/O device changes memory between the two accesses, which would otherwise raise a false fault.

The queue lets the copies drift apart in time instead of pairing their loads cycle for cycle. The leading copy stalls while the queue is full, and the trailing copy stalls while it is empty. When the trailing copy takes a value, it presents the address it computed. If that address differs from the stored one, the queue reports a fault one cycle later.

Top module: `ldval_replq`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `lead_ready`=1, `trail_ready`=0, `trail_fault`=0. A reset in the middle of operation discards all stored entries.
- R2: Values reach the trailing side in the order the leading side wrote them. `trail_data` always shows the oldest entry not yet taken.
- R3: `lead_ready` is 0 exactly when DEPTH entries are held (default 32). A write attempted while it is 0 is dropped and stores nothing.
- R4: `trail_ready` is 0 exactly when no entry is held. A take attempted while it is 0 removes nothing and raises no fault. `trail_data` reads 0 while the queue is empty.
- R5: A take (`trail_valid`=1 with `trail_ready`=1) whose `trail_addr` differs from the stored address drives `trail_fault` to 1 in the following cycle. The entry is still consumed and its data is still delivered.
- R6: `trail_fault` is 1 only in the cycle after a mismatching take. It is 0 after a matching take and after any cycle without a take.
- R7: A write and a take in the same cycle leave the number of held entries unchanged, including when one entry is held.
- R8: A write into an empty queue becomes visible on `trail_data`, with `trail_ready`=1, in the next cycle. While no take happens, `trail_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, empties the queue |
| lead_valid | input | 1 | Leading copy offers a loaded value |
| lead_ready | output | 1 | Queue can accept a value (not full) |
| lead_addr | input | AW | Address of the leading load |
| lead_data | input | DW | Value returned by the cache for that load |
| trail_valid | input | 1 | Trailing copy requests its next load value |
| trail_ready | output | 1 | A value is available (not empty) |
| trail_addr | input | AW | Address computed by the trailing copy |
| trail_data | output | DW | Head value for the trailing load, 0 when empty |
| trail_fault | output | 1 | One-cycle pulse after a take with an address mismatch |

## Verification
A burst of distinct writes followed by a burst of matching takes shows the ordering. A full fill with an extra write, then a full drain, separates a dropped overflow write from a stored one. Takes on an empty queue, including one in the same cycle as the first write, show that an empty queue refuses a take even while a write arrives. Interleaved writes and takes at one entry and at several entries exercise the unchanged occupancy. Back-to-back mismatching takes, mixed with matching ones, tell a per-take fault pulse apart from a sticky flag, and a reset under load shows that old entries are discarded.

// File: rtl/lvq_pkg.sv
// Shared helpers for the load value replication queue.
// Assumes pointer values stay below the depth they are wrapped against.
package lvq_pkg;
    // Advance a circular index, wrapping to zero after depth-1.
    function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/lvq_ptrs.sv
// Occupancy tracking for the queue: write index, read index, fill count.
// Assumes push_en is never asserted while full and pop_en never while empty
// (the top gates both); DEPTH >= 2. Reset empties the queue.
module lvq_ptrs #(
    parameter  int DEPTH = 32,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          full,
    output logic          empty
);
    import lvq_pkg::*;

    logic [CW-1:0] count;

    // Move the write index on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (push_en) wr_ptr <= PW'(wrap_next(int'(wr_ptr), DEPTH));
    end

    // Move the read index on each accepted take.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (pop_en) rd_ptr <= PW'(wrap_next(int'(rd_ptr), DEPTH));
    end

    // Keep the fill count; a write and a take together cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (push_en && !pop_en) count <= count + 1'b1;
        else if (pop_en && !push_en) count <= count - 1'b1;
    end

    // Decode the boundary flags from the count.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

    // R3: the count never exceeds the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a full queue without a take stays full
    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_en) |=> full);
    // R4: an empty queue without a write stays empty
    assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_en) |=> empty);
    // R7: a write and a take together keep the indices the same distance apart
    assert_same_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> (full == $past(full)) && (empty == $past(empty)));
    // R1: never full and empty at once
    assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/lvq_ram.sv
// Storage array for address/data entries: one write port, one
// asynchronous read port. Holds no reset; validity comes from the indices.
module lvq_ram #(
    parameter  int DEPTH = 32,
    parameter  int W     = 96,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one entry per accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the head entry without a clock.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/lvq_cmp.sv
// Address check for the trailing copy: registers a one-cycle fault pulse
// when a take's requested address differs from the stored one.
// Assumes pop_en is asserted only for an accepted take.
module lvq_cmp #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_en,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] head_addr,
    output logic          fault
);
    // Flag a mismatching take for exactly the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= pop_en && (req_addr != head_addr);
    end

    // R5: a fault pulse is always preceded by a take
    assert_fault_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(pop_en));
    // R6: a matching take never raises a fault
    assert_match_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && (req_addr == head_addr)) |=> !fault);
    // R6: no take, no fault
    assert_idle_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> !fault);
endmodule

// File: rtl/ldval_replq.sv
// Load value replication queue. The leading copy writes each cache-load
// result with its address; the trailing copy takes values in program order
// and has its address checked. Assumes fixed leading/trailing roles,
// synchronous active-low reset that flushes all entries.
module ldval_replq #(
    parameter  int DEPTH = 32,
    parameter  int AW    = 32,
    parameter  int DW    = 64,
    localparam int PW    = $clog2(DEPTH),
    localparam int EW    = AW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead_valid,
    output logic          lead_ready,
    input  logic [AW-1:0] lead_addr,
    input  logic [DW-1:0] lead_data,
    input  logic          trail_valid,
    output logic          trail_ready,
    input  logic [AW-1:0] trail_addr,
    output logic [DW-1:0] trail_data,
    output logic          trail_fault
);
    logic          full, empty, push_en, pop_en;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [EW-1:0] head;

    // Accept only on the handshake side that is free.
    always_comb begin
        lead_ready  = !full;
        trail_ready = !empty;
        push_en     = lead_valid && !full;
        pop_en      = trail_valid && !empty;
        trail_data  = empty ? '0 : head[DW-1:0];
    end

    lvq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty)
    );

    lvq_ram #(.DEPTH(DEPTH), .W(EW)) u_ram (
        .clk(clk), .we(push_en), .waddr(wr_ptr), .wdata({lead_addr, lead_data}),
        .raddr(rd_ptr), .rdata(head)
    );

    lvq_cmp #(.AW(AW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .pop_en(pop_en), .req_addr(trail_addr),
        .head_addr(head[EW-1:DW]), .fault(trail_fault)
    );

    // R8: the head value holds while nothing is taken
    assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_ready && !trail_valid) |=> $stable(trail_data));
    // R4: an empty queue shows zero data
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trail_ready |-> (trail_data == '0));
endmodule

// File: tb/ldval_replq_tb.sv
`timescale 1ns/1ps
module ldval_replq_tb;
    localparam int DEPTH = 32;
    localparam int AW    = 32;
    localparam int DW    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lead_valid = 1'b0, trail_valid = 1'b0;
    logic          lead_ready, trail_ready, trail_fault;
    logic [AW-1:0] lead_addr = '0, trail_addr = '0;
    logic [DW-1:0] lead_data = '0, trail_data;

    int checks = 0, errors = 0;
    logic [AW-1:0] sb_addr[$];
    logic [DW-1:0] sb_data[$];
    logic exp_fault = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldval_replq #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lead_valid(lead_valid), .lead_ready(lead_ready),
        .lead_addr(lead_addr), .lead_data(lead_data),
        .trail_valid(trail_valid), .trail_ready(trail_ready),
        .trail_addr(trail_addr), .trail_data(trail_data),
        .trail_fault(trail_fault)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare against the scoreboard, update it at the edge.
    task automatic step(input logic pv, input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                        input logic tv, input logic [AW-1:0] ta, input string tag);
        int n;
        bit push_ok, pop_ok;
        @(negedge clk);
        lead_valid = pv; lead_addr = pa; lead_data = pd;
        trail_valid = tv; trail_addr = ta;
        #1;
        n = sb_data.size();
        check(lead_ready == (n < DEPTH), {tag, "/R3"}, "lead_ready", 64'(lead_ready), 64'(n < DEPTH));
        check(trail_ready == (n > 0), {tag, "/R4"}, "trail_ready", 64'(trail_ready), 64'(n > 0));
        check(trail_fault == exp_fault, {tag, "/R5_R6"}, "trail_fault", 64'(trail_fault), 64'(exp_fault));
        if (n > 0) check(trail_data == sb_data[0], {tag, "/R2"}, "trail_data", trail_data, sb_data[0]);
        else       check(trail_data == '0, {tag, "/R4"}, "empty data", trail_data, '0);
        push_ok = pv && (n < DEPTH);
        pop_ok  = tv && (n > 0);
        @(posedge clk);
        exp_fault = pop_ok && (ta != sb_addr[0]);
        if (pop_ok) begin void'(sb_addr.pop_front()); void'(sb_data.pop_front()); end
        if (push_ok) begin sb_addr.push_back(pa); sb_data.push_back(pd); end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lead_valid = 1'b0; trail_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sb_addr.delete(); sb_data.delete(); exp_fault = 1'b0;
    endtask

    function automatic logic [AW-1:0] a_of(int i); return AW'(32'h1000 + i * 8); endfunction
    function automatic logic [DW-1:0] d_of(int i); return {32'(i) ^ 32'hA5A5_0000, 32'(i * 7 + 3)}; endfunction

    initial begin
        do_reset();
        // R1: reset state
        step(0, '0, '0, 0, '0, "R1");
        // R2: distinct writes, then matching takes in order
        for (int i = 0; i < 5; i++) step(1, a_of(i), d_of(i), 0, '0, "R2");
        for (int i = 0; i < 5; i++) step(0, '0, '0, 1, a_of(i), "R2");
        // R8: a single write is visible next cycle and holds while idle
        step(1, a_of(50), d_of(50), 0, '0, "R8");
        for (int i = 0; i < 3; i++) step(0, '0, '0, 0, '0, "R8");
        step(0, '0, '0, 1, a_of(50), "R8");
        // R3: fill completely, overflow write dropped, then drain
        for (int i = 0; i < DEPTH; i++) step(1, a_of(100 + i), d_of(100 + i), 0, '0, "R3");
        step(1, a_of(999), d_of(999), 0, '0, "R3");
        for (int i = 0; i < DEPTH; i++) step(0, '0, '0, 1, a_of(100 + i), "R3");
        step(0, '0, '0, 0, '0, "R3");
        // R4: take on empty is refused, also when a write arrives the same cycle
        step(0, '0, '0, 1, a_of(7), "R4");
        step(1, a_of(200), d_of(200), 1, a_of(3), "R4");
        // R7: write and take together at one entry and at several entries
        step(1, a_of(201), d_of(201), 1, a_of(200), "R7");
        for (int i = 0; i < 3; i++) step(1, a_of(202 + i), d_of(202 + i), 0, '0, "R7");
        for (int i = 0; i < 4; i++) step(1, a_of(210 + i), d_of(210 + i), 1, a_of(201 + i), "R7");
        // R5/R6: back-to-back mismatches, then a match
        step(0, '0, '0, 1, a_of(0), "R5");
        step(0, '0, '0, 1, a_of(1), "R5");
        step(0, '0, '0, 1, a_of(212), "R6");
        step(0, '0, '0, 1, a_of(99), "R5");
        step(0, '0, '0, 0, '0, "R6");
        step(0, '0, '0, 0, '0, "R6");
        // R1: reset under load discards entries
        for (int i = 0; i < 6; i++) step(1, a_of(300 + i), d_of(300 + i), 0, '0, "R1");
        do_reset();
        step(0, '0, '0, 1, a_of(300), "R1");
        step(1, a_of(400), d_of(400), 0, '0, "R1");
        step(0, '0, '0, 1, a_of(400), "R1");
        step(0, '0, '0, 0, '0, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule